// File: doc/BRIEF.md
# Load Address and Extend Unit

This unit serves the load path of a processor pipeline. Given a base register value, a 16-bit displacement and an access kind, it forms an effective address and places a single read on a simple request/acknowledge port. When the read returns, it turns the aligned 32-bit word into the value that goes to the destination register. Four access kinds are supported: signed byte load, signed halfword load, word load and word read from the I/O space.

Alignment is never trapped. Halfword accesses clear the lowest address bit, and word and I/O accesses clear the two lowest bits. Byte and halfword data are picked from the returned word in little-endian lane order and then sign-extended. The unit reads and writes no condition flags. It takes one access at a time. A start strobe that arrives while an access is still in progress is dropped.

Top module: `ldx_unit`

## Requirements
- R1: The effective address is the base value plus the displacement sign-extended to 32 bits, modulo 2^32. A byte access (kind code 0) sends this address to `rd_addr_o` unmasked.
- R2: For a byte access, the result is byte lane `ea[1:0]` of the returned word, where lane 0 is bits 7:0 and lane 3 is bits 31:24. That byte is sign-extended from its bit 7.
- R3: For a halfword access (kind code 1), `rd_addr_o` is the effective address with bit 0 cleared. The result is the halfword chosen by `ea[1]` (0 selects bits 15:0, 1 selects bits 31:16), sign-extended from its bit 15.
- R4: For a word access (kind code 2), `rd_addr_o` is the effective address with bits 1:0 cleared. The result is the returned word unchanged.
- R5: For an I/O word read (kind code 3), the address and the result follow R4, and `rd_io_o` is high together with `rd_req_o`. For kind codes 0 to 2, `rd_io_o` is low.
- R6: After reset, `rd_req_o` and `done_o` are low.
- R7: A start accepted while idle raises `rd_req_o` in the following cycle. `rd_req_o` stays high, and `rd_addr_o` stays stable, until `rd_ack_i` is sampled high.
- R8: `done_o` goes high for exactly one cycle, in the cycle after the clock edge that sampled `rd_ack_i`. In that cycle `result_o` holds the formatted value and `rd_req_o` is low.
- R9: While a request is outstanding, a start strobe is ignored. No second request is made and `rd_addr_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an access with the operands presented in this cycle |
| kind_i | input | 2 | Access kind: 0 byte, 1 halfword, 2 word, 3 I/O word |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_io_o | output | 1 | Marks the request as I/O space |
| rd_addr_o | output | 32 | Read address after alignment masking |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 32 | Aligned read data word |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Formatted destination value |

## Verification
The bench sweeps every access kind against bases that end in each of the four low-bit patterns, and against displacements at the signed extremes, around zero, and negative. Crossing the low bits with the kind separates correct lane selection and masking from off-by-one lane errors, and separates masking that is applied from masking that is skipped. Bases near the top of the address space combined with positive displacements check that the addition wraps. The memory model returns words whose lanes have mixed sign bits, so a missing or wrong sign extension shows up. Acknowledge latency varies from zero to three wait cycles, and a stray start is injected during the wait. This shows whether the request is held and whether the stray start is ignored.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

  localparam int XLEN   = 32;
  localparam int DISP_W = 16;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_PORT = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DONE = 2'd2
  } ldx_state_e;

endpackage

// File: rtl/ldx_addr_gen.sv
module ldx_addr_gen #(
  parameter int AW     = ldx_pkg::XLEN,
  parameter int DISP_W = ldx_pkg::DISP_W
) (
  input  logic [AW-1:0]     base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        kind_i,
  output logic [AW-1:0]     ea_raw_o,
  output logic [AW-1:0]     ea_aligned_o
);
  import ldx_pkg::*;

  localparam int EXT_W = AW - DISP_W;

  function automatic logic [AW-1:0] sext_disp(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [AW-1:0] size_mask(input logic [1:0] k);
    logic [AW-1:0] m;
    m = '1;
    case (acc_kind_e'(k))
      ACC_HALF:          m[0]   = 1'b0;
      ACC_WORD, ACC_PORT: m[1:0] = 2'b00;
      default:           m      = '1;
    endcase
    return m;
  endfunction

  assign ea_raw_o     = wrap_add(base_i, sext_disp(disp_i));
  assign ea_aligned_o = ea_raw_o & size_mask(kind_i);

  always_comb begin
    if (ea_aligned_o[AW-1:2] != ea_raw_o[AW-1:2])
      $error("AST_UPPER_BITS_KEPT: masking touched upper address bits"); // R1
  end

endmodule

// File: rtl/ldx_format.sv
module ldx_format #(
  parameter int DW = ldx_pkg::XLEN
) (
  input  logic [1:0]                  kind_i,
  input  logic [$clog2(DW/8)-1:0]     lane_i,
  input  logic [DW-1:0]               word_i,
  output logic [DW-1:0]               value_o
);
  import ldx_pkg::*;

  localparam int NBYTES = DW / 8;
  localparam int NHALF  = NBYTES / 2;
  localparam int LW     = $clog2(NBYTES);

  logic [7:0]  bytes_w [NBYTES];
  logic [15:0] halves_w[NHALF];
  logic [7:0]  byte_sel_w;
  logic [15:0] half_sel_w;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte_lane
    assign bytes_w[g] = word_i[8*g +: 8];
  end
  for (genvar h = 0; h < NHALF; h++) begin : g_half_lane
    assign halves_w[h] = word_i[16*h +: 16];
  end

  assign byte_sel_w = bytes_w[lane_i];
  assign half_sel_w = halves_w[lane_i[LW-1:1]];

  function automatic logic [DW-1:0] sext8(input logic [7:0] b);
    return {{(DW-8){b[7]}}, b};
  endfunction

  function automatic logic [DW-1:0] sext16(input logic [15:0] h);
    return {{(DW-16){h[15]}}, h};
  endfunction

  always_comb begin
    case (acc_kind_e'(kind_i))
      ACC_BYTE: value_o = sext8(byte_sel_w);
      ACC_HALF: value_o = sext16(half_sel_w);
      default:  value_o = word_i;
    endcase
  end

  always_comb begin
    if (kind_i == 2'd0 && value_o[DW-1:8] != {(DW-8){value_o[7]}})
      $error("AST_BYTE_EXTEND: byte result not sign-extended"); // R2
    if (kind_i == 2'd1 && value_o[DW-1:16] != {(DW-16){value_o[15]}})
      $error("AST_HALF_EXTEND: halfword result not sign-extended"); // R3
  end

endmodule

// File: rtl/ldx_ctrl.sv
module ldx_ctrl #(
  parameter int AW = ldx_pkg::XLEN,
  parameter int DW = ldx_pkg::XLEN
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [1:0]                kind_i,
  input  logic [AW-1:0]             ea_raw_i,
  input  logic [AW-1:0]             ea_aligned_i,
  input  logic                      rd_ack_i,
  input  logic [DW-1:0]             fmt_value_i,
  output logic [1:0]                kind_q_o,
  output logic [$clog2(DW/8)-1:0]   lane_q_o,
  output logic                      rd_req_o,
  output logic                      rd_io_o,
  output logic [AW-1:0]             rd_addr_o,
  output logic                      done_o,
  output logic [DW-1:0]             result_o
);
  import ldx_pkg::*;

  localparam int LW = $clog2(DW/8);

  ldx_state_e   state_q;
  logic [1:0]   kind_q;
  logic [LW-1:0] lane_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] result_q;

  logic accept_w;
  logic ack_hit_w;
  logic busy_w;

  assign busy_w    = (state_q != ST_IDLE);
  assign accept_w  = start_i && !busy_w;
  assign ack_hit_w = (state_q == ST_REQ) && rd_ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= 2'd0;
      lane_q   <= '0;
      addr_q   <= '0;
      result_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_w) begin
          state_q <= ST_REQ;
          kind_q  <= kind_i;
          lane_q  <= ea_raw_i[LW-1:0];
          addr_q  <= ea_aligned_i;
        end
        ST_REQ: if (ack_hit_w) begin
          state_q  <= ST_DONE;
          result_q <= fmt_value_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign kind_q_o  = kind_q;
  assign lane_q_o  = lane_q;
  assign rd_req_o  = (state_q == ST_REQ);
  assign rd_io_o   = (state_q == ST_REQ) && (kind_q == ACC_PORT);
  assign rd_addr_o = addr_q;
  assign done_o    = (state_q == ST_DONE);
  assign result_o  = result_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R7
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rd_req_o && rd_ack_i)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w && start_i |=> $stable(rd_addr_o)); // R9
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && kind_q[1] |-> rd_addr_o[1:0] == 2'b00); // R4
  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && kind_q == 2'd1 |-> rd_addr_o[0] == 1'b0); // R3
  AST_IO_ONLY_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_io_o |-> rd_req_o && kind_q == 2'd3); // R5

endmodule

// File: rtl/ldx_unit.sv
module ldx_unit #(
  parameter int AW     = ldx_pkg::XLEN,
  parameter int DW     = ldx_pkg::XLEN,
  parameter int DISP_W = ldx_pkg::DISP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic [AW-1:0]     base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              rd_req_o,
  output logic              rd_io_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic              done_o,
  output logic [DW-1:0]     result_o
);
  localparam int LW = $clog2(DW/8);

  logic [AW-1:0] ea_raw_w;
  logic [AW-1:0] ea_aligned_w;
  logic [1:0]    kind_q_w;
  logic [LW-1:0] lane_q_w;
  logic [DW-1:0] fmt_value_w;

  ldx_addr_gen #(.AW(AW), .DISP_W(DISP_W)) u_addr (
    .base_i       (base_i),
    .disp_i       (disp_i),
    .kind_i       (kind_i),
    .ea_raw_o     (ea_raw_w),
    .ea_aligned_o (ea_aligned_w)
  );

  ldx_format #(.DW(DW)) u_fmt (
    .kind_i  (kind_q_w),
    .lane_i  (lane_q_w),
    .word_i  (rd_data_i),
    .value_o (fmt_value_w)
  );

  ldx_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .kind_i       (kind_i),
    .ea_raw_i     (ea_raw_w),
    .ea_aligned_i (ea_aligned_w),
    .rd_ack_i     (rd_ack_i),
    .fmt_value_i  (fmt_value_w),
    .kind_q_o     (kind_q_w),
    .lane_q_o     (lane_q_w),
    .rd_req_o     (rd_req_o),
    .rd_io_o      (rd_io_o),
    .rd_addr_o    (rd_addr_o),
    .done_o       (done_o),
    .result_o     (result_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !rd_req_o && !done_o); // R6

endmodule

// File: tb/test_ldx_unit.sv
module test_ldx_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic [31:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic        rd_req_o, rd_io_o, done_o;
  logic [31:0] rd_addr_o, result_o;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ldx_unit i_ldx_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
    .base_i(base_i), .disp_i(disp_i), .rd_req_o(rd_req_o), .rd_io_o(rd_io_o),
    .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ {a[15:0], a[31:16]} ^ 32'h8070_C00F;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] k, input logic [31:0] b,
                         input logic [15:0] d, input int lat);
    logic [31:0] ea, exp_addr, word, shifted, exp_res;
    ea = b + {{16{d[15]}}, d};
    case (k)
      2'd0:    exp_addr = ea;
      2'd1:    exp_addr = {ea[31:1], 1'b0};
      default: exp_addr = {ea[31:2], 2'b00};
    endcase
    word = mem_word(exp_addr);
    if (k == 2'd0) begin
      shifted = word >> (8 * ea[1:0]);
      exp_res = {{24{shifted[7]}}, shifted[7:0]};
    end else if (k == 2'd1) begin
      shifted = word >> (16 * ea[1]);
      exp_res = {{16{shifted[15]}}, shifted[15:0]};
    end else begin
      exp_res = word;
    end

    @(negedge clk);
    start_i = 1'b1; kind_i = k; base_i = b; disp_i = d;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 request raised", {31'd0, rd_req_o}, 32'd1);
    case (k)
      2'd0: check("R1 byte address", rd_addr_o, exp_addr);
      2'd1: check("R3 halfword address", rd_addr_o, exp_addr);
      2'd2: check("R4 word address", rd_addr_o, exp_addr);
      default: check("R5 io address", rd_addr_o, exp_addr);
    endcase
    check("R5 io qualifier", {31'd0, rd_io_o}, {31'd0, k == 2'd3});
    for (int i = 0; i < lat; i++) begin
      if (i == 0) begin
        start_i = 1'b1; kind_i = ~k; base_i = b ^ 32'h0000_0155; disp_i = ~d;
      end
      @(negedge clk);
      start_i = 1'b0;
      check("R9 busy start ignored, address", rd_addr_o, exp_addr);
      check("R7 request held", {31'd0, rd_req_o}, 32'd1);
    end
    rd_ack_i = 1'b1; rd_data_i = word;
    @(negedge clk);
    rd_ack_i = 1'b0; rd_data_i = 32'hDEAD_BEEF;
    check("R8 done pulse", {31'd0, done_o}, 32'd1);
    check("R8 request dropped", {31'd0, rd_req_o}, 32'd0);
    case (k)
      2'd0: check("R2 byte result", result_o, exp_res);
      2'd1: check("R3 halfword result", result_o, exp_res);
      2'd2: check("R4 word result", result_o, exp_res);
      default: check("R5 io result", result_o, exp_res);
    endcase
    @(negedge clk);
    check("R8 done single cycle", {31'd0, done_o}, 32'd0);
    check("R9 no second request", {31'd0, rd_req_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [5];
    logic [15:0] disps [8];
    int n;
    bases = '{32'h0000_1000, 32'h7FFF_FFFD, 32'hFFFF_FFFE, 32'h8000_0003, 32'h1234_5679};
    disps = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
              16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFFD};
    repeat (3) @(negedge clk);
    check("R6 reset request low", {31'd0, rd_req_o}, 32'd0);
    check("R6 reset done low", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 idle after reset", {30'd0, rd_req_o, done_o}, 32'd0);
    n = 0;
    for (int k = 0; k < 4; k++)
      for (int bi = 0; bi < 5; bi++)
        for (int di = 0; di < 8; di++) begin
          run_one(k[1:0], bases[bi], disps[di], n % 4);
          n++;
        end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule